// File: doc/BRIEF.md
# Delayed-Branch PC Sequencer with Annul

This block holds the program counter pair of a processor that has one architectural delay slot: `pc_o` is the address of the instruction being decoded now and `npc_o` is the address that comes after it. Each cycle in which `step_i` is high, the decoder presents the control-transfer information for the instruction at `pc_o`. This information is the transfer kind, the condition result, the annul bit, the call displacement, and the jump operands with the destination index. The sequencer then moves both counters forward. A transfer that is taken changes only the next-PC. The instruction that already follows therefore runs as the delay slot before control reaches the target.

The sequencer decides whether that delay-slot instruction is squashed. A squash is shown on `kill_o` while the squashed instruction sits at `pc_o`. The sequence still advances past it, and its control inputs are ignored. For call and jump-and-link, the link write (register index and value) is driven in the same cycle as the instruction. The delay-slot instruction therefore already sees the new link value. When address masking is on, the upper half of the link value is cleared. A jump to a target that is not word-aligned raises `align_fault_o` and the counters hold.

Internally a three-state machine tracks the slot. ST_RUN is ordinary sequential flow. ST_SLOT means the instruction at `pc_o` is a delay slot that executes. ST_SQUASH means it is a delay slot that must be killed.

From ST_RUN or ST_SLOT, a step behaves as follows:
- A step that calls for a squash goes to ST_SQUASH.
- Any other step that carries a transfer kind goes to ST_SLOT.
- A plain step goes to ST_RUN.

From ST_SQUASH, the next step always returns to ST_RUN. A stall, or a step that faults, leaves the state as it is.

Top module: `dslot_pc_seq`

## Requirements
- R1: After reset `pc_o` is RESET_PC (0), `npc_o` is RESET_PC+4, and `kill_o`, `link_we_o` and `align_fault_o` are low.
- R2: On a step with kind none, `pc_o` takes the old `npc_o` and `npc_o` becomes old `npc_o`+4 at the next edge; with `step_i` low both counters hold.
- R3: Kind codes on `kind_i` are 0 none, 1 conditional, 2 always, 3 never, 4 call, 5 jump-and-link (6 and 7 act as none). A taken transfer puts its target into `npc_o` only while `pc_o` takes the old `npc_o`. A branch target is the branch's own PC plus the sign-extended 30-bit `disp_i` shifted left by 2. A never branch and an untaken conditional fall through.
- R4: A conditional branch with `annul_i` low never squashes its delay slot, taken or not.
- R5: A conditional branch with `annul_i` high squashes its delay slot when `cond_true_i` is low and keeps it when high.
- R6: An always or never branch squashes its delay slot exactly when `annul_i` is high, whatever `cond_true_i` is.
- R7: While `kill_o` is high, a step advances `pc_o` to `npc_o` and `npc_o` by 4. The step also ignores `kind_i` and every other control input: no transfer, no link write and no fault.
- R8: A call drives `link_we_o` high with `link_idx_o` 15 and `link_val_o` equal to its own `pc_o` in its own cycle, and transfers to `pc_o` + sign-extended `disp_i`×4.
- R9: Jump-and-link drives a link write of its own `pc_o` to `rd_i`. It transfers to `rs1_i`+`rs2_i` when `use_imm_i` is low, and to `rs1_i` + sign-extended 13-bit `imm_i` when it is high.
- R10: A jump-and-link with `rd_i` 0 (return-style) transfers but leaves `link_we_o` low.
- R11: With `addr_mask_i` high, bits 63:32 of `link_val_o` are zero for call and jump-and-link.
- R12: A jump-and-link whose target has nonzero low two bits raises `align_fault_o` in that cycle, writes no link, and leaves `pc_o`, `npc_o` and `kill_o` unchanged at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step_i | input | 1 | Instruction at `pc_o` completes this cycle |
| kind_i | input | 3 | Control-transfer kind code |
| cond_true_i | input | 1 | Branch condition evaluated true |
| annul_i | input | 1 | Annul bit of the branch |
| disp_i | input | 30 | Signed word displacement for branch and call |
| rs1_i | input | 64 | First jump operand |
| rs2_i | input | 64 | Second jump operand |
| imm_i | input | 13 | Signed jump immediate |
| use_imm_i | input | 1 | Jump uses the immediate instead of `rs2_i` |
| rd_i | input | 5 | Jump-and-link destination index |
| addr_mask_i | input | 1 | Address-mask mode, clears upper link half |
| pc_o | output | 64 | Current program counter |
| npc_o | output | 64 | Next program counter |
| kill_o | output | 1 | Instruction at `pc_o` is a squashed delay slot |
| link_we_o | output | 1 | Link register write enable |
| link_idx_o | output | 5 | Link register index |
| link_val_o | output | 64 | Link value |
| align_fault_o | output | 1 | Misaligned jump target |

## Verification
The bench drives the annul matrix across all three branch classes and both condition values. A design that treats a taken annulled conditional like an unconditional one would kill a slot that must run. A design that ignores annul on always or never branches would let a slot through that must be squashed. A call is placed in a squashed slot to catch a sequencer that still honours the control inputs of a killed instruction. Jumps cover negative immediates, return-style destination zero, a target above 4 GiB under address masking, and a misaligned target. Each of these catches a design that writes the wrong link, leaves the upper bits unmasked, or redirects on a fault.

// File: rtl/dslot_pc_pkg.sv
package dslot_pc_pkg;

    typedef enum logic [2:0] {
        XF_NONE    = 3'd0,
        XF_BCOND   = 3'd1,
        XF_BALWAYS = 3'd2,
        XF_BNEVER  = 3'd3,
        XF_CALL    = 3'd4,
        XF_JMPL    = 3'd5
    } xfer_e;

    typedef enum logic [1:0] {
        ST_RUN    = 2'd0,
        ST_SLOT   = 2'd1,
        ST_SQUASH = 2'd2
    } seq_state_e;

endpackage

// File: rtl/dslot_pc_target.sv
module dslot_pc_target #(
    parameter int AW     = 64,
    parameter int DISP_W = 30,
    parameter int IMM_W  = 13
) (
    input  logic [AW-1:0]     pc,
    input  logic [DISP_W-1:0] disp,
    input  logic [AW-1:0]     rs1,
    input  logic [AW-1:0]     rs2,
    input  logic [IMM_W-1:0]  imm,
    input  logic              use_imm,
    output logic [AW-1:0]     rel_tgt,
    output logic [AW-1:0]     ind_tgt,
    output logic              ind_misal
);
    localparam int DPAD = AW - DISP_W;
    localparam int IPAD = AW - IMM_W;

    logic [AW-1:0] disp_ext;
    logic [AW-1:0] imm_ext;
    logic [AW-1:0] addend;

    always_comb begin
        disp_ext  = {{DPAD{disp[DISP_W-1]}}, disp};
        imm_ext   = {{IPAD{imm[IMM_W-1]}}, imm};
        rel_tgt   = pc + (disp_ext << 2);
        addend    = use_imm ? imm_ext : rs2;
        ind_tgt   = rs1 + addend;
        ind_misal = (ind_tgt[1:0] != 2'b00);
    end
endmodule

// File: rtl/dslot_pc_annul.sv
module dslot_pc_annul
    import dslot_pc_pkg::*;
(
    input  xfer_e kind,
    input  logic  cond_true,
    input  logic  annul,
    output logic  br_taken,
    output logic  squash,
    output logic  is_cti
);
    always_comb begin
        br_taken = 1'b0;
        squash   = 1'b0;
        is_cti   = 1'b1;
        unique case (kind)
            XF_BCOND: begin
                br_taken = cond_true;
                squash   = annul && !cond_true;
            end
            XF_BALWAYS: begin
                br_taken = 1'b1;
                squash   = annul;
            end
            XF_BNEVER: begin
                squash   = annul;
            end
            XF_CALL, XF_JMPL: begin
                br_taken = 1'b1;
            end
            default: begin
                is_cti   = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/dslot_pc_link.sv
module dslot_pc_link
    import dslot_pc_pkg::*;
#(
    parameter int AW       = 64,
    parameter int IDX_W    = 5,
    parameter int LINK_REG = 15,
    parameter int MASK_W   = 32
) (
    input  xfer_e             kind,
    input  logic              fault,
    input  logic [IDX_W-1:0]  rd,
    input  logic [AW-1:0]     pc,
    input  logic              addr_mask,
    output logic              we,
    output logic [IDX_W-1:0]  idx,
    output logic [AW-1:0]     val
);
    localparam logic [IDX_W-1:0] CALL_IDX = IDX_W'(LINK_REG);

    always_comb begin
        we  = 1'b0;
        idx = '0;
        if (kind == XF_CALL) begin
            we  = 1'b1;
            idx = CALL_IDX;
        end else if (kind == XF_JMPL && !fault) begin
            we  = (rd != '0);
            idx = rd;
        end
    end

    generate
        if (AW > MASK_W) begin : g_mask
            assign val = addr_mask ? {{(AW-MASK_W){1'b0}}, pc[MASK_W-1:0]} : pc;
        end else begin : g_nomask
            logic unused_mask;
            assign unused_mask = addr_mask;
            assign val = pc;
        end
    endgenerate
endmodule

// File: rtl/dslot_pc_seq.sv
module dslot_pc_seq
    import dslot_pc_pkg::*;
#(
    parameter int          AW       = 64,
    parameter int          DISP_W   = 30,
    parameter int          IMM_W    = 13,
    parameter int          IDX_W    = 5,
    parameter int          LINK_REG = 15,
    parameter int          MASK_W   = 32,
    parameter logic [63:0] RESET_PC = 64'h0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_i,
    input  logic [2:0]        kind_i,
    input  logic              cond_true_i,
    input  logic              annul_i,
    input  logic [DISP_W-1:0] disp_i,
    input  logic [AW-1:0]     rs1_i,
    input  logic [AW-1:0]     rs2_i,
    input  logic [IMM_W-1:0]  imm_i,
    input  logic              use_imm_i,
    input  logic [IDX_W-1:0]  rd_i,
    input  logic              addr_mask_i,
    output logic [AW-1:0]     pc_o,
    output logic [AW-1:0]     npc_o,
    output logic              kill_o,
    output logic              link_we_o,
    output logic [IDX_W-1:0]  link_idx_o,
    output logic [AW-1:0]     link_val_o,
    output logic              align_fault_o
);
    localparam logic [AW-1:0] PC0  = AW'(RESET_PC);
    localparam logic [AW-1:0] STEP = AW'(4);

    seq_state_e    state_q, state_d;
    logic [AW-1:0] pc_q, npc_q, pc_d, npc_d;
    xfer_e         kind_dec, kind_eff;
    logic          live;
    logic          br_taken, squash, is_cti;
    logic [AW-1:0] rel_tgt, ind_tgt;
    logic          ind_misal, fault;

    always_comb begin
        unique case (kind_i)
            3'd1:    kind_dec = XF_BCOND;
            3'd2:    kind_dec = XF_BALWAYS;
            3'd3:    kind_dec = XF_BNEVER;
            3'd4:    kind_dec = XF_CALL;
            3'd5:    kind_dec = XF_JMPL;
            default: kind_dec = XF_NONE;
        endcase
        live     = step_i && (state_q != ST_SQUASH);
        kind_eff = live ? kind_dec : XF_NONE;
    end

    dslot_pc_target #(.AW(AW), .DISP_W(DISP_W), .IMM_W(IMM_W)) u_target (
        .pc        (pc_q),
        .disp      (disp_i),
        .rs1       (rs1_i),
        .rs2       (rs2_i),
        .imm       (imm_i),
        .use_imm   (use_imm_i),
        .rel_tgt   (rel_tgt),
        .ind_tgt   (ind_tgt),
        .ind_misal (ind_misal)
    );

    dslot_pc_annul u_annul (
        .kind      (kind_eff),
        .cond_true (cond_true_i),
        .annul     (annul_i),
        .br_taken  (br_taken),
        .squash    (squash),
        .is_cti    (is_cti)
    );

    assign fault = (kind_eff == XF_JMPL) && ind_misal;

    dslot_pc_link #(.AW(AW), .IDX_W(IDX_W), .LINK_REG(LINK_REG), .MASK_W(MASK_W)) u_link (
        .kind      (kind_eff),
        .fault     (fault),
        .rd        (rd_i),
        .pc        (pc_q),
        .addr_mask (addr_mask_i),
        .we        (link_we_o),
        .idx       (link_idx_o),
        .val       (link_val_o)
    );

    // Next-state and counter update
    always_comb begin
        state_d = state_q;
        pc_d    = pc_q;
        npc_d   = npc_q;
        if (step_i && !fault) begin
            pc_d  = npc_q;
            npc_d = br_taken ? ((kind_eff == XF_JMPL) ? ind_tgt : rel_tgt)
                             : npc_q + STEP;
            unique case (state_q)
                ST_SQUASH: state_d = ST_RUN;
                ST_RUN, ST_SLOT: begin
                    if (squash)      state_d = ST_SQUASH;
                    else if (is_cti) state_d = ST_SLOT;
                    else             state_d = ST_RUN;
                end
                default: state_d = ST_RUN;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
            pc_q    <= PC0;
            npc_q   <= PC0 + STEP;
        end else begin
            state_q <= state_d;
            pc_q    <= pc_d;
            npc_q   <= npc_d;
        end
    end

    // Outputs
    always_comb begin
        pc_o          = pc_q;
        npc_o         = npc_q;
        kill_o        = (state_q == ST_SQUASH);
        align_fault_o = fault;
    end

    AST_SEQ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !kill_o && kind_i == 3'd0) |=> (pc_o == $past(npc_o) && npc_o == $past(npc_o) + STEP)); // R2
    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !step_i |=> ($stable(pc_o) && $stable(npc_o))); // R2
    AST_COND_ANNUL_SQUASH: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !kill_o && kind_i == 3'd1 && annul_i && !cond_true_i) |=> kill_o); // R5
    AST_UNCOND_ANNUL_SQUASH: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !kill_o && (kind_i == 3'd2 || kind_i == 3'd3) && annul_i) |=> kill_o); // R6
    AST_KILLED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        kill_o |-> (!link_we_o && !align_fault_o)); // R7
    AST_FAULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        align_fault_o |=> ($stable(pc_o) && $stable(npc_o))); // R12
endmodule

// File: tb/dslot_pc_seq_tb_top.sv
module dslot_pc_seq_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        step_i = 1'b0;
    logic [2:0]  kind_i = '0;
    logic        cond_true_i = 1'b0;
    logic        annul_i = 1'b0;
    logic [29:0] disp_i = '0;
    logic [63:0] rs1_i = '0;
    logic [63:0] rs2_i = '0;
    logic [12:0] imm_i = '0;
    logic        use_imm_i = 1'b0;
    logic [4:0]  rd_i = '0;
    logic        addr_mask_i = 1'b0;
    logic [63:0] pc_o, npc_o, link_val_o;
    logic        kill_o, link_we_o, align_fault_o;
    logic [4:0]  link_idx_o;

    always #(CLK_PERIOD/2) clk = ~clk;

    dslot_pc_seq dut_i (
        .clk(clk), .rst_n(rst_n), .step_i(step_i), .kind_i(kind_i),
        .cond_true_i(cond_true_i), .annul_i(annul_i), .disp_i(disp_i),
        .rs1_i(rs1_i), .rs2_i(rs2_i), .imm_i(imm_i), .use_imm_i(use_imm_i),
        .rd_i(rd_i), .addr_mask_i(addr_mask_i), .pc_o(pc_o), .npc_o(npc_o),
        .kill_o(kill_o), .link_we_o(link_we_o), .link_idx_o(link_idx_o),
        .link_val_o(link_val_o), .align_fault_o(align_fault_o)
    );

    typedef struct {
        logic [63:0] pc;
        logic [63:0] npc;
        logic        kill;
        string       req;
    } exp_t;

    exp_t        sb_q[$];
    int          checks = 0;
    int          errors = 0;
    bit          done = 0;
    logic [63:0] m_pc = 64'h0;
    logic [63:0] m_npc = 64'h4;
    logic        m_kill = 1'b0;

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Monitor: pops expected state after each edge
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            chk(e.req, "pc", pc_o, e.pc);
            chk(e.req, "npc", npc_o, e.npc);
            chk(e.req, "kill", {63'd0, kill_o}, {63'd0, e.kill});
        end
    end

    task automatic push_exp(input string req);
        exp_t e;
        e.pc = m_pc; e.npc = m_npc; e.kill = m_kill; e.req = req;
        sb_q.push_back(e);
    endtask

    task automatic idle(input string req);
        @(negedge clk);
        step_i = 1'b0;
        #1;
        chk(req, "stall link_we", {63'd0, link_we_o}, 64'd0);
        push_exp(req);
    endtask

    task automatic drive(input logic [2:0] k, input logic c, input logic a, input logic [29:0] d,
                         input logic [63:0] r1, input logic [63:0] r2, input logic [12:0] im,
                         input logic ui, input logic [4:0] rd, input logic am, input string req);
        logic [63:0] rel, ind, tgt, exp_val, new_pc;
        logic [4:0]  exp_idx;
        logic        exp_we, exp_f, taken, nk;
        @(negedge clk);
        step_i = 1'b1; kind_i = k; cond_true_i = c; annul_i = a; disp_i = d;
        rs1_i = r1; rs2_i = r2; imm_i = im; use_imm_i = ui; rd_i = rd; addr_mask_i = am;
        #1;
        exp_we = 0; exp_idx = 0; exp_val = 0; exp_f = 0; taken = 0; nk = 0;
        if (m_kill) begin
            m_pc = m_npc;
            m_npc = m_npc + 64'd4;
            m_kill = 1'b0;
        end else begin
            rel = m_pc + ({{34{d[29]}}, d} << 2);
            ind = r1 + (ui ? {{51{im[12]}}, im} : r2);
            tgt = rel;
            case (k)
                3'd1: begin taken = c; nk = a && !c; end
                3'd2: begin taken = 1; nk = a; end
                3'd3: nk = a;
                3'd4: begin taken = 1; exp_we = 1; exp_idx = 5'd15; exp_val = m_pc; end
                3'd5: begin
                    tgt = ind;
                    if (ind[1:0] != 2'b00) exp_f = 1;
                    else begin taken = 1; exp_we = (rd != 0); exp_idx = rd; exp_val = m_pc; end
                end
                default: ;
            endcase
            if (am) exp_val[63:32] = 32'h0;
            if (!exp_f) begin
                new_pc = m_npc;
                m_npc = taken ? tgt : m_npc + 64'd4;
                m_pc = new_pc;
                m_kill = nk;
            end
        end
        chk(req, "link_we", {63'd0, link_we_o}, {63'd0, exp_we});
        chk(req, "align_fault", {63'd0, align_fault_o}, {63'd0, exp_f});
        if (exp_we) begin
            chk(req, "link_idx", {59'd0, link_idx_o}, {59'd0, exp_idx});
            chk(req, "link_val", link_val_o, exp_val);
        end
        push_exp(req);
    endtask

    task automatic plain(input string req);
        drive(3'd0, 0, 0, '0, '0, '0, '0, 0, '0, 0, req);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1", "pc", pc_o, 64'h0);
        chk("R1", "npc", npc_o, 64'h4);
        chk("R1", "kill", {63'd0, kill_o}, 64'd0);
        chk("R1", "link_we", {63'd0, link_we_o}, 64'd0);
        chk("R1", "fault", {63'd0, align_fault_o}, 64'd0);

        plain("R2"); plain("R2"); plain("R2");
        idle("R2"); idle("R2");
        drive(3'd7, 1, 1, 30'd9, '0, '0, '0, 0, 5'd3, 0, "R3");   // code 7 acts as none
        // R3 / R4: conditional taken, annul clear
        drive(3'd1, 1, 0, 30'd4, '0, '0, '0, 0, '0, 0, "R4");
        plain("R3");
        plain("R3");
        // R4: conditional untaken, annul clear
        drive(3'd1, 0, 0, 30'd8, '0, '0, '0, 0, '0, 0, "R4");
        plain("R4");
        // R5: taken with annul keeps slot
        drive(3'd1, 1, 1, 30'h3FFF_FFFE, '0, '0, '0, 0, '0, 0, "R5");
        plain("R5");
        plain("R5");
        // R5: untaken with annul squashes; R7 call in killed slot ignored
        drive(3'd1, 0, 1, 30'd20, '0, '0, '0, 0, '0, 0, "R5");
        drive(3'd4, 0, 0, 30'd100, '0, '0, '0, 0, '0, 0, "R7");
        plain("R7");
        // R6: always/never with annul set squash, clear keeps
        drive(3'd2, 0, 1, 30'd16, '0, '0, '0, 0, '0, 0, "R6");
        drive(3'd5, 0, 0, '0, 64'h3, '0, '0, 0, 5'd7, 0, "R7");
        plain("R6");
        drive(3'd3, 1, 1, 30'd16, '0, '0, '0, 0, '0, 0, "R6");
        plain("R6");
        drive(3'd2, 1, 0, 30'h3FFF_FFF0, '0, '0, '0, 0, '0, 0, "R6");
        plain("R6");
        drive(3'd3, 1, 0, 30'd5, '0, '0, '0, 0, '0, 0, "R3");
        plain("R6");
        plain("R3");
        // R8: call with negative displacement
        drive(3'd4, 0, 1, 30'h3FFF_FFFC, '0, '0, '0, 0, '0, 0, "R8");
        plain("R8");
        plain("R8");
        // R9: register-register jump, then negative immediate
        drive(3'd5, 0, 0, '0, 64'h2000, 64'h40, '0, 0, 5'd9, 0, "R9");
        plain("R9");
        drive(3'd5, 0, 0, '0, 64'h3000, 64'h5, 13'h1FF8, 1, 5'd12, 0, "R9");
        plain("R9");
        // R10: return-style jump
        drive(3'd5, 0, 0, '0, 64'h500, '0, 13'h10, 1, 5'd0, 0, "R10");
        plain("R10");
        // R11: move above 4 GiB, then masked links
        drive(3'd5, 0, 0, '0, 64'h1_0000_0100, 64'h0, '0, 0, 5'd4, 0, "R11");
        plain("R11");
        drive(3'd4, 0, 0, 30'd8, '0, '0, '0, 0, '0, 1, "R11");
        plain("R11");
        drive(3'd5, 0, 0, '0, 64'h1_0000_0200, '0, 13'h8, 1, 5'd20, 1, "R11");
        plain("R11");
        // R12: misaligned target
        drive(3'd5, 0, 0, '0, 64'h7000, 64'h2, '0, 0, 5'd8, 0, "R12");
        drive(3'd5, 0, 0, '0, 64'h7000, '0, 13'h1, 1, 5'd8, 0, "R12");
        plain("R12");
        idle("R2");
        @(negedge clk);
        step_i = 1'b0;
        repeat (3) @(negedge clk);
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule